// File: doc/BRIEF.md
# I2C Configuration Register Slave for an Audio Controller

This block is the write-only two-wire control port of an audio processing chip. A fast system clock oversamples the SCL and SDA lines through synchronizers and a glitch filter, from which START and STOP conditions and clock edges are derived. A transfer consists of these bytes in order:

- the 7-bit device address plus the direction bit;
- a subaddress byte that picks one of sixteen 8-bit registers and may set a pointer step flag;
- any number of data bytes, written into the bank.

The slave pulls SDA low through an open-drain enable during the acknowledge clock of every byte it accepts.

Each data byte takes effect at the moment its acknowledge clock begins, not at the STOP. The whole bank is available as a flat vector for the rest of the chip. Two registers are also decoded into named fields: the source-selector register gives source, input gain and differential attenuation, and the mute register gives soft-mute and the zero-crossing window. Soft-mute can also be forced by an external active-low pin.

The controller is a state machine with these states:

- `ST_IDLE`: waiting for a START.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging the address.
- `ST_SUB`: shifting in the subaddress.
- `ST_SUB_ACK`: acknowledging the subaddress.
- `ST_DATA`: shifting in a data byte.
- `ST_DATA_ACK`: acknowledging a data byte.
- `ST_READ`: bus released after a read request.
- `ST_IGNORE`: address mismatch; the bus is ignored.

Transitions:

- A START moves any state to `ST_ADDR`. A STOP moves any state to `ST_IDLE`.
- At the falling SCL edge after eight bits:
  - `ST_ADDR` goes to `ST_ADDR_ACK` on an address match, or to `ST_IGNORE` otherwise.
  - `ST_SUB` goes to `ST_SUB_ACK`.
  - `ST_DATA` goes to `ST_DATA_ACK`. This is also where the data byte is written.
- At the falling SCL edge that ends an acknowledge clock:
  - `ST_ADDR_ACK` goes to `ST_SUB` for a write, or to `ST_READ` for a read.
  - `ST_SUB_ACK` goes to `ST_DATA`.
  - `ST_DATA_ACK` goes back to `ST_DATA`, advancing the pointer if the step flag is set.

Top module: `i2c_ctrl_regbank`

## Requirements
- R1: After synchronous reset every register reads zero. As a result `cfg_bank` is all zero, `src_sel`, `in_gain`, `diff_m6` and `zc_win` are zero, `sda_oe` is low, and `soft_mute` is low while `mute_n` is high.
- R2: A byte 0x88 following a START (device address 7'b1000100, direction bit 0 = write) is acknowledged: SDA is held low throughout the ninth clock.
- R3: An address byte with any other 7-bit address gets no acknowledge. The slave then acknowledges nothing and writes nothing until the next START.
- R4: The subaddress byte is acknowledged. Its bits [3:0] load the register pointer and bit 4 is the step flag; bits [7:5] have no effect.
- R5: When the step flag is 1, the pointer increments by one after each data byte and wraps from 15 to 0.
- R6: When the step flag is 0, every data byte of the transfer is written to the same register, so the last byte remains.
- R7: Each data byte is written at the falling SCL edge that starts its acknowledge clock. It is visible on the outputs before any STOP is sent.
- R8: In register 0, bits [2:0] drive `src_sel` (000 differential input 3, 001 input 2, 010 input 1, 011 mono), bits [4:3] drive `in_gain` (00 = 11.25 dB, 01 = 7.5 dB, 10 = 3.75 dB, 11 = 0 dB), and bit 6 drives `diff_m6` (1 = -6 dB).
- R9: In register 1, bits [6:5] drive `zc_win` as {bit 6, bit 5}. `soft_mute` is register 1 bit 0 OR the inverse of `mute_n`, with `mute_n` passed through a two-flop synchronizer.
- R10: A START in the middle of a byte discards that byte without touching any register and restarts address matching.
- R11: The address byte 0x89 (direction bit 1 = read) is acknowledged. After that the slave keeps SDA released and writes nothing until the next START or STOP.
- R12: A pulse on SCL or SDA that lasts fewer than FILT_LEN system clocks is ignored.
- R13: `sda_oe` is high only during acknowledge clocks, changes only while the filtered SCL is low, and is low after a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | SCL line level |
| sda_in | input | 1 | SDA line level |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |
| mute_n | input | 1 | External soft-mute request, active low |
| src_sel | output | 3 | Source selection, register 0 bits [2:0] |
| in_gain | output | 2 | Input gain code, register 0 bits [4:3] |
| diff_m6 | output | 1 | Differential -6 dB, register 0 bit 6 |
| zc_win | output | 2 | Zero-crossing window, register 1 bits [6:5] |
| soft_mute | output | 1 | Soft-mute active, active high |
| cfg_bank | output | NREG*8 | All registers, register n at bits [8n+7:8n] |

## Verification
The checker watches four properties on every cycle:

- the acknowledge enable rises only while the filtered SCL is low, and holds still during SCL-high phases;
- every register write is followed at once by an asserted acknowledge;
- a START always releases SDA;
- the bank is zero when reset ends.

Address matching and the side effects of the bus are only visible through whole transfers driven by the bench. These cover pointer loading and wrap, single-register streaming, field decoding, rejection of read and mismatched addresses, aborted bytes and filtered SCL glitches.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    // subaddress layout
    localparam int AI_BIT = 4;

    // source-selector register fields
    localparam int SEL_SRC_LSB  = 0;
    localparam int SEL_GAIN_LSB = 3;
    localparam int SEL_DIFF_BIT = 6;

    // mute register fields
    localparam int MUTE_SM_BIT  = 0;
    localparam int MUTE_ZC_LSB  = 5;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_READ,
        ST_IGNORE
    } slv_state_e;

endpackage

// File: rtl/i2c_glitch_filter.sv
module i2c_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int FC_W = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FC_W-1:0]        run_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
            run_q  <= '0;
            level  <= 1'b1;
            rise   <= 1'b0;
            fall   <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            rise   <= 1'b0;
            fall   <= 1'b0;
            if (synced != level) begin
                if (run_q == FC_W'(FILT_LEN - 1)) begin
                    level <= synced;
                    rise  <= synced;
                    fall  <= ~synced;
                    run_q <= '0;
                end else begin
                    run_q <= run_q + FC_W'(1);
                end
            end else begin
                run_q <= '0;
            end
        end
    end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b1000100,
    parameter int         AW       = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sda_f,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [AW-1:0]     wr_idx,
    output logic [BYTE_W-1:0] wr_data
);
    slv_state_e        state, nxt_state;
    logic [BYTE_W-1:0] shreg;
    logic [CNT_W-1:0]  bit_cnt;
    logic [AW-1:0]     ptr;
    logic              auto_inc;
    logic              byte_done;
    logic              in_byte;
    logic              in_ack;

    assign byte_done = (bit_cnt == CNT_W'(BYTE_W));
    assign in_byte   = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);
    assign in_ack    = (state == ST_ADDR_ACK) || (state == ST_SUB_ACK) || (state == ST_DATA_ACK);

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt_state;
    end

    // next state
    always_comb begin
        nxt_state = state;
        if (start_det) begin
            nxt_state = ST_ADDR;
        end else if (stop_det) begin
            nxt_state = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt_state = ST_IDLE;
                ST_ADDR:     if (scl_fall && byte_done)
                                 nxt_state = (shreg[7:1] == DEV_ADDR) ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) nxt_state = shreg[0] ? ST_READ : ST_SUB;
                ST_SUB:      if (scl_fall && byte_done) nxt_state = ST_SUB_ACK;
                ST_SUB_ACK:  if (scl_fall) nxt_state = ST_DATA;
                ST_DATA:     if (scl_fall && byte_done) nxt_state = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt_state = ST_DATA;
                ST_READ:     nxt_state = ST_READ;
                ST_IGNORE:   nxt_state = ST_IGNORE;
                default:     nxt_state = ST_IDLE;
            endcase
        end
    end

    // shift register, bit counter and register pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            shreg    <= '0;
            bit_cnt  <= '0;
            ptr      <= '0;
            auto_inc <= 1'b0;
        end else if (start_det) begin
            bit_cnt <= '0;
        end else begin
            if (in_byte && scl_rise && !byte_done) begin
                shreg   <= {shreg[BYTE_W-2:0], sda_f};
                bit_cnt <= bit_cnt + CNT_W'(1);
            end
            if (in_ack && scl_fall) begin
                bit_cnt <= '0;
            end
            if (state == ST_SUB && nxt_state == ST_SUB_ACK) begin
                ptr      <= shreg[AW-1:0];
                auto_inc <= shreg[AI_BIT];
            end
            if (state == ST_DATA_ACK && nxt_state == ST_DATA && auto_inc) begin
                ptr <= ptr + AW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe  = in_ack;
        wr_en   = (state == ST_DATA) && (nxt_state == ST_DATA_ACK);
        wr_idx  = ptr;
        wr_data = shreg;
    end
endmodule

// File: rtl/i2c_cfg_regfile.sv
module i2c_cfg_regfile
    import i2c_cfg_pkg::*;
#(
    parameter int NREG     = 16,
    parameter int AW       = 4,
    parameter int SEL_IDX  = 0,
    parameter int MUTE_IDX = 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_idx,
    input  logic [BYTE_W-1:0]      wr_data,
    input  logic                   mute_n,
    output logic [2:0]             src_sel,
    output logic [1:0]             in_gain,
    output logic                   diff_m6,
    output logic [1:0]             zc_win,
    output logic                   soft_mute,
    output logic [NREG*BYTE_W-1:0] cfg_bank
);
    logic [BYTE_W-1:0] reg_q [NREG];
    logic [1:0]        mute_s;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [AW-1:0] IDX = AW'(g);
        always_ff @(posedge clk) begin
            if (rst)                         reg_q[g] <= '0;
            else if (wr_en && wr_idx == IDX) reg_q[g] <= wr_data;
        end
        assign cfg_bank[g*BYTE_W +: BYTE_W] = reg_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst) mute_s <= 2'b11;
        else     mute_s <= {mute_s[0], mute_n};
    end

    assign src_sel   = reg_q[SEL_IDX][SEL_SRC_LSB +: 3];
    assign in_gain   = reg_q[SEL_IDX][SEL_GAIN_LSB +: 2];
    assign diff_m6   = reg_q[SEL_IDX][SEL_DIFF_BIT];
    assign zc_win    = reg_q[MUTE_IDX][MUTE_ZC_LSB +: 2];
    assign soft_mute = reg_q[MUTE_IDX][MUTE_SM_BIT] | ~mute_s[1];
endmodule

// File: rtl/i2c_ctrl_regbank.sv
module i2c_ctrl_regbank
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1000100,
    parameter int         NREG        = 16,
    parameter int         SEL_IDX     = 0,
    parameter int         MUTE_IDX    = 1,
    parameter int         SYNC_STAGES = 2,
    parameter int         FILT_LEN    = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   scl_in,
    input  logic                   sda_in,
    output logic                   sda_oe,
    input  logic                   mute_n,
    output logic [2:0]             src_sel,
    output logic [1:0]             in_gain,
    output logic                   diff_m6,
    output logic [1:0]             zc_win,
    output logic                   soft_mute,
    output logic [NREG*BYTE_W-1:0] cfg_bank
);
    localparam int AW = $clog2(NREG);

    logic [1:0]        raw_in;
    logic [1:0]        lvl, rise, fall;
    logic              scl_f, sda_f;
    logic              start_det, stop_det;
    logic              wr_en;
    logic [AW-1:0]     wr_idx;
    logic [BYTE_W-1:0] wr_data;

    assign raw_in = {sda_in, scl_in};

    for (genvar i = 0; i < 2; i++) begin : g_line
        i2c_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_in[i]),
            .level(lvl[i]),
            .rise (rise[i]),
            .fall (fall[i])
        );
    end

    assign scl_f     = lvl[0];
    assign sda_f     = lvl[1];
    assign start_det = fall[1] & scl_f;
    assign stop_det  = rise[1] & scl_f;

    i2c_slave_fsm #(
        .DEV_ADDR(DEV_ADDR),
        .AW      (AW)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .sda_f    (sda_f),
        .scl_rise (rise[0]),
        .scl_fall (fall[0]),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_oe   (sda_oe),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    i2c_cfg_regfile #(
        .NREG    (NREG),
        .AW      (AW),
        .SEL_IDX (SEL_IDX),
        .MUTE_IDX(MUTE_IDX)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .mute_n   (mute_n),
        .src_sel  (src_sel),
        .in_gain  (in_gain),
        .diff_m6  (diff_m6),
        .zc_win   (zc_win),
        .soft_mute(soft_mute),
        .cfg_bank (cfg_bank)
    );
endmodule

// File: rtl/i2c_ctrl_regbank_chk.sv
module i2c_ctrl_regbank_chk #(
    parameter int NB = 128
) (
    input logic          clk,
    input logic          rst,
    input logic          scl_f,
    input logic          sda_oe,
    input logic          wr_en,
    input logic          start_det,
    input logic [NB-1:0] cfg_bank
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!sda_oe && cfg_bank == '0));

    // R13
    ack_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f);

    // R13
    ack_hold_high_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_f && $past(scl_f)) |-> $stable(sda_oe));

    // R7
    commit_then_ack_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> sda_oe);

    // R10
    start_release_chk: assert property (@(posedge clk) disable iff (rst)
        start_det |=> !sda_oe);
endmodule

bind i2c_ctrl_regbank i2c_ctrl_regbank_chk #(.NB(NREG*8)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .scl_f    (scl_f),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .start_det(start_det),
    .cfg_bank (cfg_bank)
);

// File: tb/i2c_ctrl_regbank_tb.sv
module i2c_ctrl_regbank_tb;
    localparam int NREG = 16;
    localparam int Q    = 25;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic mute_n = 1'b1;
    logic sda_line;
    logic sda_oe;
    logic [2:0] src_sel;
    logic [1:0] in_gain;
    logic diff_m6;
    logic [1:0] zc_win;
    logic soft_mute;
    logic [NREG*8-1:0] cfg_bank;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_ctrl_regbank u_dut (
        .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line), .sda_oe(sda_oe),
        .mute_n(mute_n), .src_sel(src_sel), .in_gain(in_gain), .diff_m6(diff_m6),
        .zc_win(zc_win), .soft_mute(soft_mute), .cfg_bank(cfg_bank)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic q_wait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; q_wait();
        scl_m = 1'b1; q_wait();
        sda_m = 1'b0; q_wait();
        scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        q_wait(); sda_m = 1'b0;
        q_wait(); scl_m = 1'b1;
        q_wait(); sda_m = 1'b1;
        q_wait();
    endtask

    task automatic send_bit(input logic b, input bit glitch, output logic seen);
        if (glitch) begin
            repeat (8) @(negedge clk); scl_m = 1'b1;
            repeat (2) @(negedge clk); scl_m = 1'b0;
            repeat (Q - 10) @(negedge clk);
        end else begin
            q_wait();
        end
        sda_m = b; q_wait();
        scl_m = 1'b1; q_wait();
        seen = sda_line; q_wait();
        scl_m = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit glitch, output bit ack);
        logic s;
        for (int i = 7; i >= 0; i--) send_bit(d[i], glitch, s);
        send_bit(1'b1, 1'b0, s);
        ack = !s;
    endtask

    function automatic logic [7:0] reg_at(input int idx);
        return cfg_bank[idx*8 +: 8];
    endfunction

    task automatic t_reset();
        chk("R1 bank", cfg_bank == '0, 1);
        chk("R1 src_sel", src_sel, 0);
        chk("R1 in_gain", in_gain, 0);
        chk("R1 diff_m6", diff_m6, 0);
        chk("R1 zc_win", zc_win, 0);
        chk("R1 soft_mute", soft_mute, 0);
        chk("R1 sda_oe", sda_oe, 0);
    endtask

    task automatic t_single_write();
        bit a;
        bus_start();
        send_byte(8'h88, 0, a); chk("R2 address ack", a, 1);
        send_byte(8'h00, 0, a); chk("R4 subaddress ack", a, 1);
        chk("R7 not yet written", src_sel, 0);
        send_byte(8'h49, 0, a); chk("R2 data ack", a, 1);
        chk("R7 R8 src_sel before stop", src_sel, 3'd1);
        chk("R8 in_gain", in_gain, 2'd1);
        chk("R8 diff_m6", diff_m6, 1);
        bus_stop();
        chk("R13 released after stop", sda_oe, 0);
    endtask

    task automatic t_auto_inc();
        bit a;
        bus_start();
        send_byte(8'h88, 0, a);
        send_byte(8'h10, 0, a);
        send_byte(8'h13, 0, a);
        send_byte(8'h61, 0, a); chk("R5 second byte ack", a, 1);
        bus_stop();
        chk("R5 R8 src_sel", src_sel, 3'd3);
        chk("R8 in_gain 3.75dB code", in_gain, 2'd2);
        chk("R8 diff_m6 clear", diff_m6, 0);
        chk("R9 zc_win", zc_win, 2'd3);
        chk("R9 soft_mute from register", soft_mute, 1);
    endtask

    task automatic t_wrap();
        bit a;
        bus_start();
        send_byte(8'h88, 0, a);
        send_byte(8'hFF, 0, a); chk("R4 subaddress with high bits set ack", a, 1);
        send_byte(8'hAA, 0, a);
        send_byte(8'h1A, 0, a);
        bus_stop();
        chk("R4 R5 reg15", reg_at(15), 8'hAA);
        chk("R5 wrap to reg0 src_sel", src_sel, 3'd2);
        chk("R5 wrap to reg0 in_gain", in_gain, 2'd3);
    endtask

    task automatic t_no_inc();
        bit a;
        bus_start();
        send_byte(8'h88, 0, a);
        send_byte(8'h01, 0, a);
        send_byte(8'h01, 0, a);
        send_byte(8'h20, 0, a);
        bus_stop();
        chk("R6 reg1 last byte", reg_at(1), 8'h20);
        chk("R6 reg2 untouched", reg_at(2), 8'h00);
        chk("R9 zc_win", zc_win, 2'd1);
        chk("R9 soft_mute off", soft_mute, 0);
        chk("R6 reg0 untouched", reg_at(0), 8'h1A);
    endtask

    task automatic t_mute_pin();
        mute_n = 1'b0;
        repeat (5) @(negedge clk);
        chk("R9 pin forces soft_mute", soft_mute, 1);
        mute_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R9 pin released", soft_mute, 0);
    endtask

    task automatic t_bad_addr();
        bit a;
        bus_start();
        send_byte(8'h8A, 0, a); chk("R3 mismatched address nack", a, 0);
        send_byte(8'h00, 0, a); chk("R3 following byte nack", a, 0);
        send_byte(8'h07, 0, a); chk("R3 data nack", a, 0);
        bus_stop();
        chk("R3 reg0 unchanged", reg_at(0), 8'h1A);
    endtask

    task automatic t_read();
        bit a;
        bus_start();
        send_byte(8'h89, 0, a); chk("R11 read address ack", a, 1);
        send_byte(8'h00, 0, a); chk("R11 sda released", a, 0);
        send_byte(8'h05, 0, a); chk("R11 still released", a, 0);
        bus_stop();
        chk("R11 reg0 unchanged", reg_at(0), 8'h1A);
    endtask

    task automatic t_abort();
        bit a;
        logic s;
        bus_start();
        send_byte(8'h88, 0, a);
        send_byte(8'h00, 0, a);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 0, s);
        bus_start();
        send_byte(8'h88, 0, a); chk("R10 restart address ack", a, 1);
        send_byte(8'h02, 0, a);
        send_byte(8'h3C, 0, a);
        bus_stop();
        chk("R10 aborted byte not written", reg_at(0), 8'h1A);
        chk("R10 new transfer written", reg_at(2), 8'h3C);
    endtask

    task automatic t_glitch();
        bit a;
        bus_start();
        send_byte(8'h88, 0, a);
        send_byte(8'h00, 0, a);
        send_byte(8'h0B, 1, a); chk("R12 ack with glitches", a, 1);
        bus_stop();
        chk("R12 reg0 intact", reg_at(0), 8'h0B);
        chk("R12 src_sel", src_sel, 3'd3);
        chk("R13 idle sda_oe", sda_oe, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        t_reset();
        t_single_write();
        t_auto_inc();
        t_wrap();
        t_no_inc();
        t_mute_pin();
        t_bad_addr();
        t_read();
        t_abort();
        t_glitch();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule